// File: doc/BRIEF.md
# Soft Interrupt Request Register

This block keeps a 17-bit word of pending soft interrupt requests and a 4-bit processor interrupt level. Software reaches both through one small access port with four selects. One select writes the whole word. A second select sets bits in the word, and a third select removes bits from it. The fourth select holds the processor interrupt level.

Two timer match inputs raise the lowest and the highest bit of the word in hardware. The remaining fifteen bits are the software levels. The pending level is the index of the highest set bit in the word. The block compares that level against the processor interrupt level and produces an interrupt request. It also sends a one-cycle recheck pulse to the core in two cases: when the pending level rises, and when the processor interrupt level is rewritten.

Every access is gated by a privilege input. An unprivileged access reports a fault and changes nothing.

Top module: `sirq_reg`

## Requirements
- R1: A privileged write with select 0 replaces the whole request word with the write data.
- R2: A privileged write with select 1 stores the OR of the write data and the current word.
- R3: A privileged write with select 2 stores the current word ANDed with the complement of the write data.
- R4: Any access made while `priv_i` is low raises `fault_o` in the next cycle and returns zero read data. It leaves both the word and the processor interrupt level unchanged.
- R5: The pending level is the index of the highest set bit of the word, and zero when the word is empty. `recheck_o` pulses for one cycle after any update that raises the pending level. It stays low when the level falls or stays the same.
- R6: A privileged write with select 3 loads write data bits [3:0] into the processor interrupt level and pulses `recheck_o` in the next cycle.
- R7: `tick_match_i` sets bit 0 and `stick_match_i` sets bit 16. Both are applied after any software update in the same cycle, so a software write in that cycle cannot clear them.
- R8: `irq_o` is high exactly when the pending level is strictly greater than the processor interrupt level and `int_en_i` is high.
- R9: A privileged read returns data in the next cycle, as follows:
  - select 0 returns the word;
  - select 3 returns the processor interrupt level in bits [3:0];
  - selects 1 and 2 return zero.
- R10: After reset the word and the processor interrupt level are zero, and `irq_o` and `recheck_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| acc_sel_i | input | 2 | 0 = word, 1 = set bits, 2 = clear bits, 3 = interrupt level |
| acc_wdata_i | input | 17 | Write data |
| priv_i | input | 1 | High when the access is privileged |
| tick_match_i | input | 1 | Tick compare match; sets bit 0 |
| stick_match_i | input | 1 | System tick compare match; sets bit 16 |
| int_en_i | input | 1 | Global interrupt enable |
| rdata_o | output | 17 | Read data, registered |
| fault_o | output | 1 | Privileged-opcode fault, registered |
| recheck_o | output | 1 | One-cycle interrupt recheck pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench adds a low bit through the set select while a higher bit is already pending. A design that pulses on any change, rather than only on a rise, would show a false recheck pulse here. It also checks the equal-level case of the comparator: with the interrupt level set to 4 and the pending level at 4, `irq_o` must stay low, and a design that used greater-or-equal would raise it. A direct write of zero is issued in the same cycle as a tick match, to confirm that the hardware bit wins over the software write. Unprivileged writes of all-ones are followed by privileged reads, which show that neither register was touched.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [1:0] {
    SEL_WORD = 2'd0,
    SEL_SET  = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_PIL  = 2'd3
  } sel_e;
endpackage

// File: rtl/sirq_prio_enc.sv
module sirq_prio_enc #(
  parameter int W  = 17,
  parameter int LW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [LW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = LW'(i);
    end
  end
endmodule

// File: rtl/sirq_word_upd.sv
module sirq_word_upd
  import sirq_pkg::*;
#(
  parameter int WORD_W = 17
) (
  input  logic [WORD_W-1:0] cur_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  sel_e              sel_i,
  input  logic              wr_en_i,
  input  logic              tick_i,
  input  logic              stick_i,
  output logic [WORD_W-1:0] nxt_o
);
  logic [WORD_W-1:0] sw_word;
  logic [WORD_W-1:0] hw_bits;

  always_comb begin
    sw_word = cur_i;
    if (wr_en_i) begin
      unique case (sel_i)
        SEL_WORD: sw_word = wdata_i;
        SEL_SET:  sw_word = cur_i | wdata_i;
        SEL_CLR:  sw_word = cur_i & ~wdata_i;
        default:  sw_word = cur_i;
      endcase
    end
  end

  always_comb begin
    hw_bits           = '0;
    hw_bits[0]        = tick_i;
    hw_bits[WORD_W-1] = stick_i;
  end

  // hardware match bits override a same-cycle software clear
  assign nxt_o = sw_word | hw_bits;
endmodule

// File: rtl/sirq_access.sv
module sirq_access
  import sirq_pkg::*;
#(
  parameter int WORD_W = 17,
  parameter int PIL_W  = 4
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  sel_e              sel_i,
  input  logic              priv_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [PIL_W-1:0]  pil_i,
  output logic              fault_o,
  output logic              wr_word_o,
  output logic              wr_pil_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic ok;

  assign ok        = valid_i && priv_i;
  assign fault_o   = valid_i && !priv_i;
  assign wr_word_o = ok && write_i && (sel_i != SEL_PIL);
  assign wr_pil_o  = ok && write_i && (sel_i == SEL_PIL);

  always_comb begin
    rdata_o = '0;
    if (ok && !write_i) begin
      unique case (sel_i)
        SEL_WORD: rdata_o = word_i;
        SEL_PIL:  rdata_o = WORD_W'(pil_i);
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sirq_reg.sv
module sirq_reg
  import sirq_pkg::*;
#(
  parameter int WORD_W = 17,
  parameter int PIL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [1:0]        acc_sel_i,
  input  logic [WORD_W-1:0] acc_wdata_i,
  input  logic              priv_i,
  input  logic              tick_match_i,
  input  logic              stick_match_i,
  input  logic              int_en_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              fault_o,
  output logic              recheck_o,
  output logic              irq_o
);
  localparam int LVL_W = $clog2(WORD_W);

  sel_e              sel;
  logic [WORD_W-1:0] word_q, word_nxt;
  logic [PIL_W-1:0]  pil_q;
  logic [LVL_W-1:0]  lvl_cur, lvl_nxt;
  logic              acc_fault, wr_word, wr_pil;
  logic [WORD_W-1:0] rd_nxt;
  logic [WORD_W-1:0] rdata_q;
  logic              fault_q, recheck_q;

  assign sel = sel_e'(acc_sel_i);

  sirq_access #(.WORD_W(WORD_W), .PIL_W(PIL_W)) u_acc (
    .valid_i  (acc_valid_i),
    .write_i  (acc_write_i),
    .sel_i    (sel),
    .priv_i   (priv_i),
    .word_i   (word_q),
    .pil_i    (pil_q),
    .fault_o  (acc_fault),
    .wr_word_o(wr_word),
    .wr_pil_o (wr_pil),
    .rdata_o  (rd_nxt)
  );

  sirq_word_upd #(.WORD_W(WORD_W)) u_upd (
    .cur_i  (word_q),
    .wdata_i(acc_wdata_i),
    .sel_i  (sel),
    .wr_en_i(wr_word),
    .tick_i (tick_match_i),
    .stick_i(stick_match_i),
    .nxt_o  (word_nxt)
  );

  sirq_prio_enc #(.W(WORD_W), .LW(LVL_W)) u_enc_cur (
    .vec_i(word_q),
    .idx_o(lvl_cur)
  );

  sirq_prio_enc #(.W(WORD_W), .LW(LVL_W)) u_enc_nxt (
    .vec_i(word_nxt),
    .idx_o(lvl_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q    <= '0;
      pil_q     <= '0;
      rdata_q   <= '0;
      fault_q   <= 1'b0;
      recheck_q <= 1'b0;
    end else begin
      word_q    <= word_nxt;
      if (wr_pil) pil_q <= acc_wdata_i[PIL_W-1:0];
      rdata_q   <= rd_nxt;
      fault_q   <= acc_fault;
      recheck_q <= (lvl_nxt > lvl_cur) || wr_pil;
    end
  end

  assign rdata_o   = rdata_q;
  assign fault_o   = fault_q;
  assign recheck_o = recheck_q;
  assign irq_o     = int_en_i && (int'(lvl_cur) > int'(pil_q));

  a_r1_direct_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_write_i && priv_i && acc_sel_i == 2'd0 && !tick_match_i && !stick_match_i
    |=> word_q == $past(acc_wdata_i));

  a_r4_fault_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !priv_i |=> fault_o && rdata_o == '0);

  a_r4_no_touch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !priv_i && !tick_match_i && !stick_match_i |=> $stable(word_q) && $stable(pil_q));

  a_r5_rise_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_cur > $past(lvl_cur) |-> recheck_o);

  a_r6_pil_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_write_i && priv_i && acc_sel_i == 2'd3 |=> recheck_o);

  a_r7_tick_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_match_i |=> word_q[0]);

  a_r8_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> int_en_i);

  a_r9_alias_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !acc_write_i && priv_i && (acc_sel_i == 2'd1 || acc_sel_i == 2'd2)
    |=> rdata_o == '0);
endmodule

// File: tb/tb_sirq_reg.sv
`timescale 1ns/1ps
module tb_sirq_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_sel = 2'd0;
  logic [16:0] acc_wdata = '0;
  logic        priv = 1'b0, tick_m = 1'b0, stick_m = 1'b0, int_en = 1'b0;
  logic [16:0] rdata;
  logic        fault, recheck, irq;

  int total = 0, bad = 0;

  typedef struct {
    logic [16:0] rdata;
    logic        fault;
    logic        recheck;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [16:0] m_word = '0;
  logic [3:0]  m_pil = '0;

  always #4 clk = ~clk;

  sirq_reg dut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_sel_i(acc_sel),
    .acc_wdata_i(acc_wdata), .priv_i(priv), .tick_match_i(tick_m),
    .stick_match_i(stick_m), .int_en_i(int_en),
    .rdata_o(rdata), .fault_o(fault), .recheck_o(recheck), .irq_o(irq)
  );

  function automatic int lvl(logic [16:0] w);
    int r = 0;
    for (int i = 0; i < 17; i++) if (w[i]) r = i;
    return r;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [1:0] s,
                       input logic [16:0] d, input logic p, input logic tm,
                       input logic sm, input logic en, input string tag);
    exp_t e;
    logic [16:0] old;
    logic pil_wr;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_sel = s; acc_wdata = d;
    priv = p; tick_m = tm; stick_m = sm; int_en = en;
    @(posedge clk);
    old = m_word; pil_wr = 1'b0;
    e.rdata = '0; e.fault = 1'b0;
    if (v && !p) e.fault = 1'b1;
    else if (v && w) begin
      case (s)
        2'd0: m_word = d;
        2'd1: m_word = m_word | d;
        2'd2: m_word = m_word & ~d;
        default: begin m_pil = d[3:0]; pil_wr = 1'b1; end
      endcase
    end else if (v) begin
      if (s == 2'd0) e.rdata = old;
      else if (s == 2'd3) e.rdata = {13'd0, m_pil};
    end
    if (tm) m_word[0] = 1'b1;
    if (sm) m_word[16] = 1'b1;
    e.recheck = (lvl(m_word) > lvl(old)) || pil_wr;
    e.irq = en && (lvl(m_word) > int'(m_pil));
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "rdata", int'(rdata), int'(e.rdata));
        check(e.tag, "fault", int'(fault), int'(e.fault));
        check(e.tag, "recheck", int'(recheck), int'(e.recheck));
        check(e.tag, "irq", int'(irq), int'(e.irq));
      end
    end
  end

  initial begin : watchdog
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    #1;
    check("R10", "recheck at reset", int'(recheck), 0);
    check("R10", "irq at reset", int'(irq), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    drive(0, 0, 0, 17'h0, 1, 0, 0, 1, "R10 idle");
    drive(1, 0, 0, 17'h0, 1, 0, 0, 1, "R10/R9 read word");
    drive(1, 0, 3, 17'h0, 1, 0, 0, 1, "R10/R9 read pil");
    drive(1, 1, 0, 17'h00010, 1, 0, 0, 1, "R1/R5 direct write rise");
    drive(1, 0, 0, 17'h0, 1, 0, 0, 1, "R1/R9 read back");
    drive(0, 0, 0, 17'h0, 1, 0, 0, 1, "R5 pulse one cycle");
    drive(1, 1, 1, 17'h00100, 1, 0, 0, 1, "R2/R5 set higher");
    drive(1, 1, 1, 17'h00002, 1, 0, 0, 1, "R2/R5 set lower no pulse");
    drive(1, 0, 1, 17'h0, 1, 0, 0, 1, "R9 set alias reads zero");
    drive(1, 0, 2, 17'h0, 1, 0, 0, 1, "R9 clear alias reads zero");
    drive(1, 1, 2, 17'h00100, 1, 0, 0, 1, "R3/R5 clear top bit");
    drive(1, 0, 0, 17'h0, 1, 0, 0, 1, "R3 read back");
    drive(1, 1, 0, 17'h1FFFF, 0, 0, 0, 1, "R4 unpriv write word");
    drive(1, 1, 3, 17'h0000F, 0, 0, 0, 1, "R4 unpriv write pil");
    drive(1, 0, 0, 17'h0, 0, 0, 0, 1, "R4 unpriv read");
    drive(1, 0, 0, 17'h0, 1, 0, 0, 1, "R4 word untouched");
    drive(1, 0, 3, 17'h0, 1, 0, 0, 1, "R4 pil untouched");
    drive(1, 1, 3, 17'h00003, 1, 0, 0, 1, "R6/R8 pil=3 irq");
    drive(1, 1, 3, 17'h00004, 1, 0, 0, 1, "R6/R8 pil=4 equal no irq");
    drive(1, 1, 3, 17'h00000, 1, 0, 0, 0, "R8 enable low");
    drive(0, 0, 0, 17'h0, 1, 0, 0, 1, "R8 enable high");
    drive(1, 1, 0, 17'h00000, 1, 0, 0, 1, "R1 clear all");
    drive(0, 0, 0, 17'h0, 1, 1, 0, 1, "R7 tick match");
    drive(0, 0, 0, 17'h0, 1, 0, 1, 1, "R7/R5 stick match");
    drive(1, 0, 0, 17'h0, 1, 0, 0, 1, "R7 read word");
    drive(1, 1, 0, 17'h00000, 1, 1, 0, 1, "R7 tick beats write");
    drive(1, 0, 0, 17'h0, 1, 0, 0, 1, "R7 read after race");
    drive(1, 1, 0, 17'h00041, 1, 0, 0, 1, "R5 rise to 6");
    drive(1, 1, 0, 17'h00040, 1, 0, 0, 1, "R5 same level no pulse");
    drive(0, 0, 0, 17'h0, 1, 0, 0, 1, "R5 idle");
    repeat (3) @(posedge clk);
    #5;
    check("end", "queue drained", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule